// File: doc/BRIEF.md
# Run-Length and Frequency Lock Monitor

This block watches a clock-recovery loop and decides whether the loop may follow the incoming data or must fall back to the local reference. When it falls back, the loop behaves as a clock synthesizer. Two independent tests feed that decision.

- **Transition density.** The block counts recovered bit times since the last rising data edge. A rising edge is a sampled 1 that follows a sampled 0.
- **Frequency.** The block counts recovered-clock ticks across a window of reference-scaled ticks. It then compares that count with the ideal count.

A fault is declared on a coarse frequency error (1000 ppm). A fault is cleared only on a fine frequency error (250 ppm) in a window that also had no run-length violation. The band between the two thresholds is hysteresis.

Two active-low status flags report the fault. Each flag has its own active-low enable. A disabled flag stays High. After reset, the block starts locked to the reference, so an enabled flag reads Low until a clean window has passed. All inputs are synchronous to one system clock. The tick inputs are single-cycle strobes.

Top module: `lock_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `lock_data` is 0 (lock to reference) until the first window that meets the clear conditions has ended.
- R2: While `lock_data` is 1, a recovered tick that makes the gap since the last rising edge exceed `RUN_LIMIT` bit times clears `lock_data` on the next clock edge. This does not wait for a window boundary.
- R3: Rising edges spaced exactly `RUN_LIMIT` bit times apart never cause a run-length fault.
- R4: A window closes on the cycle that carries its 2^`WIN_LOG2`-th reference tick. A recovered tick on that same cycle belongs to the closing window. If the window's recovered count differs from 2^`WIN_LOG2` by more than floor(2^`WIN_LOG2`·`FAULT_PPM`/10^6), `lock_data` is cleared.
- R5: An error above the clear bound but not above the fault bound leaves `lock_data` unchanged, whether it is 0 or 1.
- R6: `lock_data` goes from 0 to 1 at a window close only if two conditions hold. The error must be at most floor(2^`WIN_LOG2`·`CLEAR_PPM`/10^6). No run-length violation may have occurred in that window.
- R7: `stat_a_n` is High whenever `en_a_n` is 1. When `en_a_n` is 0, `stat_a_n` equals `lock_data`.
- R8: `stat_b_n` behaves like `stat_a_n`, using `en_b_n`.
- R9: `lock_data` rises only on the clock edge that closes a window, never inside one.
- R10: `data_bit` is sampled only on cycles where `rec_tick` is 1. A line held at 1 has no rising edges and counts as a run-length violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference-scaled bit time |
| rec_tick | input | 1 | One-cycle strobe per recovered bit time |
| data_bit | input | 1 | Serial data, valid when `rec_tick` is 1 |
| en_a_n | input | 1 | Active-low enable for status A |
| en_b_n | input | 1 | Active-low enable for status B |
| lock_data | output | 1 | 1: loop follows data; 0: loop follows reference |
| stat_a_n | output | 1 | Active-low fault status A |
| stat_b_n | output | 1 | Active-low fault status B |

## Verification
Windows are driven with recovered counts at the ideal value, inside the clear bound, inside the hysteresis band, and past the fault bound on both the fast and the slow side. Comparing the lock state across these windows separates the two thresholds and shows the error is taken as a magnitude. Edge spacings of exactly the limit and one bit beyond it, plus a line stuck High, pin down where the run-length fault begins and that only rising edges reset the gap. A mid-window sample confirms that a run-length fault acts at once, while relocking waits for a window close. Random enables and random data on non-tick cycles show that the status gating follows each enable separately and that unsampled data is ignored.

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int RUN_LIMIT = 128,
  parameter int WIN_LOG2  = 16,
  parameter int FAULT_PPM = 1000,
  parameter int CLEAR_PPM = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic rec_tick,
  input  logic data_bit,
  input  logic en_a_n,
  input  logic en_b_n,
  output logic lock_data,
  output logic stat_a_n,
  output logic stat_b_n
);

  localparam int     RW        = $clog2(RUN_LIMIT + 1);
  localparam int     CW        = WIN_LOG2 + 2;
  localparam int     EW        = CW + 1;
  localparam longint WIN_LEN   = 64'd1 << WIN_LOG2;
  localparam longint FAULT_DIF = (WIN_LEN * FAULT_PPM) / 1000000;
  localparam longint CLEAR_DIF = (WIN_LEN * CLEAR_PPM) / 1000000;
  localparam logic [EW-1:0] IDEAL     = EW'(WIN_LEN);
  localparam logic [EW-1:0] FAULT_LIM = EW'(FAULT_DIF);
  localparam logic [EW-1:0] CLEAR_LIM = EW'(CLEAR_DIF);
  localparam logic [RW-1:0] RUN_TOP   = RW'(RUN_LIMIT);
  localparam logic [RW-1:0] RUN_EDGE  = RW'(RUN_LIMIT - 1);

  logic [RW-1:0]       run_cnt;
  logic                prev_bit;
  logic [WIN_LOG2-1:0] ref_cnt;
  logic [CW-1:0]       rec_cnt;
  logic                gap_seen;

  logic          rise, run_hit, win_end, fault_now, clear_ok;
  logic [EW-1:0] rec_total, freq_err;

  // edge detection and run-length test
  assign rise    = rec_tick & data_bit & ~prev_bit;
  assign run_hit = rec_tick & ~rise & (run_cnt >= RUN_EDGE);

  // frequency window
  assign win_end   = ref_tick & (&ref_cnt);
  assign rec_total = {1'b0, rec_cnt} + EW'(rec_tick);
  assign freq_err  = (rec_total >= IDEAL) ? rec_total - IDEAL : IDEAL - rec_total;

  // decision
  assign fault_now = run_hit | (win_end & (freq_err > FAULT_LIM));
  assign clear_ok  = win_end & (freq_err <= CLEAR_LIM) & ~gap_seen & ~run_hit;

  assign stat_a_n = en_a_n | lock_data;
  assign stat_b_n = en_b_n | lock_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      prev_bit  <= 1'b0;
      ref_cnt   <= '0;
      rec_cnt   <= '0;
      gap_seen  <= 1'b0;
      lock_data <= 1'b0;
    end else begin
      if (rec_tick) begin
        prev_bit <= data_bit;
        if (rise)                  run_cnt <= '0;
        else if (run_cnt != RUN_TOP) run_cnt <= run_cnt + 1'b1;
      end

      if (ref_tick) ref_cnt <= ref_cnt + 1'b1;

      if (win_end)                        rec_cnt <= '0;
      else if (rec_tick && rec_cnt != '1) rec_cnt <= rec_cnt + 1'b1;

      if (win_end)      gap_seen <= 1'b0;
      else if (run_hit) gap_seen <= 1'b1;

      if (lock_data && fault_now)      lock_data <= 1'b0;
      else if (!lock_data && clear_ok) lock_data <= 1'b1;
    end
  end

  AST_RESET_UNLOCK: assert property (@(posedge clk) !rst_n |=> !lock_data); // R1
  AST_RUN_DROP:     assert property (@(posedge clk) disable iff (!rst_n)
                      run_hit |=> !lock_data); // R2
  AST_FREQ_DROP:    assert property (@(posedge clk) disable iff (!rst_n)
                      (win_end && freq_err > FAULT_LIM) |=> !lock_data); // R4
  AST_CLEAR_COND:   assert property (@(posedge clk) disable iff (!rst_n)
                      (!lock_data && !clear_ok) |=> !lock_data); // R6
  AST_RISE_AT_WIN:  assert property (@(posedge clk) disable iff (!rst_n)
                      (!lock_data && !win_end) |=> !lock_data); // R9
  AST_STAT_A_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
                      (lock_data && fault_now && !en_a_n) |=> !stat_a_n); // R7
  AST_STAT_B_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
                      (lock_data && fault_now && !en_b_n) |=> !stat_b_n); // R8
  AST_IDLE_DATA:    assert property (@(posedge clk) disable iff (!rst_n)
                      !rec_tick |=> $stable(prev_bit) && $stable(run_cnt)); // R10

endmodule

// File: tb/lock_monitor_tb.sv
module lock_monitor_tb;
  localparam int CLK_NS = 10;
  localparam int WLOG   = 12;
  localparam int LIM    = 128;
  localparam int WTICK  = 1 << WLOG;
  localparam int WCYC   = 2 * WTICK;
  localparam int FDIF   = (WTICK * 1000) / 1000000;
  localparam int CDIF   = (WTICK * 250) / 1000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b0, rec_tick = 1'b0, data_bit = 1'b0;
  logic en_a_n = 1'b0, en_b_n = 1'b1;
  logic lock_data, stat_a_n, stat_b_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int ph = 0, g = 0;
  logic mprev = 1'b0, mlock = 1'b0;
  string last_tag = "R1";

  lock_monitor #(.RUN_LIMIT(LIM), .WIN_LOG2(WLOG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rec_tick(rec_tick),
    .data_bit(data_bit), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .lock_data(lock_data), .stat_a_n(stat_a_n), .stat_b_n(stat_b_n));

  always #(CLK_NS/2) clk = ~clk;

  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic exp_stat(logic en_n, logic lk);
    return en_n | lk;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic end_checks();
    chk(last_tag, lock_data, mlock);
    chk("R7", stat_a_n, exp_stat(en_a_n, mlock));
    chk("R8", stat_b_n, exp_stat(en_b_n, mlock));
  endtask

  task automatic run_window(string tag, int n, int per, bit stk, bit sv, bit ea, bit eb);
    logic lock0;
    bit viol = 1'b0;
    for (int k = 0; k < WCYC; k++) begin
      @(negedge clk);
      if (k == 0) begin
        end_checks();
        en_a_n = ea;
        en_b_n = eb;
        lock0  = mlock;
      end
      if (k == WCYC/2) chk("R2/R9", lock_data, lock0 & ~viol);
      ref_tick = k[0];
      rec_tick = (((k + 1) * n) / WCYC) != ((k * n) / WCYC);
      if (rec_tick) begin
        logic d;
        if (stk) d = sv;
        else begin
          d  = (ph == 0);
          ph = (ph == 0) ? per - 1 : ph - 1;
        end
        data_bit = d;
        if (d && !mprev) g = 0;
        else begin
          if (g < LIM) g++;
          if (g >= LIM) viol = 1'b1;
        end
        mprev = d;
      end else begin
        data_bit = 1'($urandom);
      end
    end
    if (mlock) begin
      if (viol || absdiff(n, WTICK) > FDIF) mlock = 1'b0;
    end else if (!viol && absdiff(n, WTICK) <= CDIF) begin
      mlock = 1'b1;
    end
    last_tag = tag;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", lock_data, 1'b0);
    chk("R1", stat_a_n, 1'b0);
    chk("R1", stat_b_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", lock_data, 1'b0);

    run_window("R6", WTICK,     64,  0, 0, 0, 0);
    run_window("R3", WTICK + 3, LIM, 0, 0, 0, 1);
    run_window("R4", WTICK + 5, 16,  0, 0, 1, 0);
    run_window("R5", WTICK + 2, 8,   0, 0, 0, 0);
    run_window("R6", WTICK - 1, 32,  0, 0, 1, 1);
    run_window("R2", WTICK,     LIM + 1, 0, 0, 0, 0);
    run_window("R10", WTICK,    16,  1, 1, 0, 1);
    run_window("R6", WTICK,     2,   0, 0, 1, 0);
    run_window("R4", WTICK - 5, 50,  0, 0, 0, 0);
    for (int w = 0; w < 6; w++) begin
      int n = WTICK + int'($urandom_range(12)) - 6;
      int per = ($urandom_range(4) == 0) ? int'($urandom_range(300, LIM + 1))
                                         : int'($urandom_range(LIM, 2));
      run_window("R5", n, per, 0, 0, 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    end_checks();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule